// File: doc/BRIEF.md
# Security-Aware Head Rest Selector

In a set-associative cache built on shift-based storage, several lines share one read/write head. The position where the head rests between accesses leaks timing to anyone who probes the set afterwards. This block picks that resting position after every access, in a way that cannot be steered by a more privileged thread. Every way's metadata carries a security level and a recency rank. The selector looks only at ways holding valid lines and finds the lowest security level among them. Among the lines at that level it takes the most recently used one. That way's index goes to a downstream head positioner. This block does not update recency and does not move the track.

The comparison is a balanced tree of two-input merge nodes whose size follows the `WAYS` parameter. The tree is purely combinational. A small controller with two states, `ST_BLANK` and `ST_HOLD`, captures the tree's result when the access-done strobe is seen.

- `ST_BLANK` is entered at reset and means no result exists yet. It moves to `ST_HOLD` on the transition *capture*, which is a clock edge with the strobe high.
- `ST_HOLD` stays in place on *recapture* (strobe high, a new result is latched) and on *keep* (strobe low, the result is held).

Top module: `head_rest_picker`

## Requirements
- R1: Each way's level is a 2-bit field at bits [2i+1:2i] of the level bus, with 00 the lowest and 11 the highest. The chosen way has the smallest level among all valid ways.
- R2: Each way's recency is a 3-bit field at bits [3i+2:3i] of the recency bus, with 000 the least recent and larger values more recent. Among valid ways at the smallest level, the chosen way has the largest recency.
- R3: When several valid ways tie on both level and recency, the lowest way index is chosen.
- R4: A way whose valid bit (bit i of the valid bus) is 0 never influences the result, whatever its level or recency.
- R5: When no way is valid at the capturing edge, the result flag is 0 and the way index is 0.
- R6: The result is taken from the inputs present at a rising clock edge where the strobe is 1. It is visible right after that edge and stays unchanged across every edge where the strobe is 0.
- R7: While reset (active low) is asserted, and until the first capture, the result flag is 0 and the way index is 0.
- R8: When at least one way is valid at the capturing edge, the result flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Access-done strobe; a result is captured on each edge where it is high |
| way_valid_i | input | WAYS | Valid bit per way |
| way_level_i | input | 2*WAYS | Security level per way, way i at [2i+1:2i] |
| way_recency_i | input | 3*WAYS | Recency rank per way, way i at [3i+2:3i] |
| rest_way_o | output | $clog2(WAYS) | Index of the chosen resting way |
| rest_valid_o | output | 1 | A valid way was chosen |

## Verification
Several properties are checked on every clock cycle. The result must hold while the strobe is low. An empty set must yield flag 0 and index 0. The chosen way must have been valid, and no valid way may carry a lower level than it. Recency ordering and the tie-break toward the lowest index depend on the values of several ways at once. Those can only be shown by the bench's vector table and its directed cases, which compare the chosen index with hand-derived answers. The bench's directed cases also cover reset, hold and recapture.

// File: rtl/head_rest_pkg.sv
package head_rest_pkg;
    localparam int LVL_W = 2;
    localparam int REC_W = 3;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] lvl;
        logic [REC_W-1:0] rec;
    } cand_t;

    typedef enum logic [0:0] {
        ST_BLANK = 1'b0,
        ST_HOLD  = 1'b1
    } rest_state_e;

    // Returns 1 when the right candidate must replace the left one.
    // Ties go to the left, which always holds the lower way index.
    function automatic logic right_wins(cand_t l, cand_t r);
        logic res;
        if (!r.valid)          res = 1'b0;
        else if (!l.valid)     res = 1'b1;
        else if (r.lvl < l.lvl) res = 1'b1;
        else if (r.lvl > l.lvl) res = 1'b0;
        else                   res = (r.rec > l.rec);
        return res;
    endfunction
endpackage

// File: rtl/rest_merge_node.sv
module rest_merge_node
    import head_rest_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  cand_t            a_i,
    input  logic [IDX_W-1:0] a_idx_i,
    input  cand_t            b_i,
    input  logic [IDX_W-1:0] b_idx_i,
    output cand_t            y_o,
    output logic [IDX_W-1:0] y_idx_o
);
    logic take_b;

    always_comb begin
        take_b  = right_wins(a_i, b_i);
        y_o     = take_b ? b_i : a_i;
        y_idx_o = take_b ? b_idx_i : a_idx_i;
    end
endmodule

// File: rtl/rest_pick_tree.sv
module rest_pick_tree
    import head_rest_pkg::*;
#(
    parameter int WAYS = 8,
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int POW   = 1 << IDX_W,
    localparam int NODES = 2 * POW - 1
) (
    input  logic [WAYS-1:0]       valid_i,
    input  logic [WAYS*LVL_W-1:0] lvl_i,
    input  logic [WAYS*REC_W-1:0] rec_i,
    output cand_t                 best_o,
    output logic [IDX_W-1:0]      best_idx_o
);
    cand_t            heap [NODES];
    logic [IDX_W-1:0] hidx [NODES];

    // Leaves sit at POW-1 .. 2*POW-2 in way order; padding leaves are empty.
    for (genvar i = 0; i < POW; i++) begin : g_leaf
        if (i < WAYS) begin : g_real
            assign heap[POW-1+i] = '{valid: valid_i[i],
                                     lvl:   lvl_i[i*LVL_W +: LVL_W],
                                     rec:   rec_i[i*REC_W +: REC_W]};
        end else begin : g_pad
            assign heap[POW-1+i] = '0;
        end
        assign hidx[POW-1+i] = IDX_W'(i);
    end

    // Internal node n merges its children 2n+1 (left, lower ways) and 2n+2.
    for (genvar n = 0; n < POW - 1; n++) begin : g_node
        rest_merge_node #(.IDX_W(IDX_W)) u_node (
            .a_i     (heap[2*n+1]),
            .a_idx_i (hidx[2*n+1]),
            .b_i     (heap[2*n+2]),
            .b_idx_i (hidx[2*n+2]),
            .y_o     (heap[n]),
            .y_idx_o (hidx[n])
        );
    end

    assign best_o     = heap[0];
    assign best_idx_o = hidx[0];
endmodule

// File: rtl/head_rest_picker.sv
module head_rest_picker
    import head_rest_pkg::*;
#(
    parameter int WAYS = 8,
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  done_i,
    input  logic [WAYS-1:0]       way_valid_i,
    input  logic [WAYS*LVL_W-1:0] way_level_i,
    input  logic [WAYS*REC_W-1:0] way_recency_i,
    output logic [IDX_W-1:0]      rest_way_o,
    output logic                  rest_valid_o
);
    rest_state_e      state_q, state_d;
    cand_t            best;
    logic [IDX_W-1:0] best_idx;
    logic [IDX_W-1:0] way_q;
    logic             valid_q;

    rest_pick_tree #(.WAYS(WAYS)) u_tree (
        .valid_i    (way_valid_i),
        .lvl_i      (way_level_i),
        .rec_i      (way_recency_i),
        .best_o     (best),
        .best_idx_o (best_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: if (done_i) state_d = ST_HOLD;   // capture
            ST_HOLD:  state_d = ST_HOLD;               // recapture or keep
            default:  state_d = ST_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            way_q   <= '0;
            valid_q <= 1'b0;
        end else if (done_i) begin
            valid_q <= best.valid;
            way_q   <= best.valid ? best_idx : '0;
        end
    end

    assign rest_valid_o = (state_q == ST_HOLD) && valid_q;
    assign rest_way_o   = way_q;
endmodule

// File: rtl/head_rest_checker.sv
module head_rest_checker
    import head_rest_pkg::*;
#(
    parameter int WAYS = 8,
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  done_i,
    input logic [WAYS-1:0]       way_valid_i,
    input logic [WAYS*LVL_W-1:0] way_level_i,
    input logic [IDX_W-1:0]      rest_way_o,
    input logic                  rest_valid_o
);
    logic [WAYS-1:0]       cap_valid;
    logic [WAYS*LVL_W-1:0] cap_lvl;
    logic [LVL_W-1:0]      chosen_lvl;
    logic                  lower_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_valid <= '0;
            cap_lvl   <= '0;
        end else if (done_i) begin
            cap_valid <= way_valid_i;
            cap_lvl   <= way_level_i;
        end
    end

    always_comb begin
        chosen_lvl = cap_lvl[rest_way_o*LVL_W +: LVL_W];
        lower_seen = 1'b0;
        for (int j = 0; j < WAYS; j++)
            if (cap_valid[j] && cap_lvl[j*LVL_W +: LVL_W] < chosen_lvl)
                lower_seen = 1'b1;
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(rest_way_o) && $stable(rest_valid_o));

    assert_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && way_valid_i == '0 |=> !rest_valid_o && rest_way_o == '0);

    assert_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && way_valid_i != '0 |=> rest_valid_o);

    assert_chosen_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rest_valid_o |-> cap_valid[rest_way_o]);

    assert_min_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rest_valid_o |-> !lower_seen);
endmodule

bind head_rest_picker head_rest_checker #(.WAYS(WAYS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_i       (done_i),
    .way_valid_i  (way_valid_i),
    .way_level_i  (way_level_i),
    .rest_way_o   (rest_way_o),
    .rest_valid_o (rest_valid_o)
);

// File: tb/sim_head_rest_picker.sv
`timescale 1ns/1ps
module sim_head_rest_picker;
    localparam int WAYS = 8;
    localparam int NV   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_i = 1'b0;
    logic [7:0]  way_valid_i = '0;
    logic [15:0] way_level_i = '0;
    logic [23:0] way_recency_i = '0;
    logic [2:0]  rest_way_o;
    logic        rest_valid_o;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    head_rest_picker #(.WAYS(WAYS)) u0 (
        .clk, .rst_n, .done_i, .way_valid_i, .way_level_i,
        .way_recency_i, .rest_way_o, .rest_valid_o
    );

    // {valid[7:0], level[15:0], recency[23:0], exp_valid, exp_way[2:0]}
    localparam logic [51:0] VEC [NV] = '{
        {8'hFF, 16'h0000, 24'hFAC688, 1'b1, 3'd7},  // R2 recency only
        {8'hFF, 16'hFBEF, 24'hFF7EFF, 1'b1, 3'd5},  // R1 lowest level wins over recency
        {8'hFF, 16'h5555, 24'h924924, 1'b1, 3'd0},  // R3 full tie
        {8'hFF, 16'h4551, 24'hB6DB6D, 1'b1, 3'd1},  // R3 tie between ways 1 and 6
        {8'hFE, 16'hFFFC, 24'hFAC68F, 1'b1, 3'd7},  // R4 invalid low-level way ignored
        {8'h00, 16'h0000, 24'hFFFFFF, 1'b0, 3'd0},  // R5 empty set
        {8'h10, 16'hFFFF, 24'h000000, 1'b1, 3'd4},  // R4 single valid way
        {8'hFF, 16'hFFAA, 24'hFFF396, 1'b1, 3'd0}   // R2 max recency within level, tie to lower
    };

    task automatic check(input string req, input logic av, input logic [2:0] aw,
                         input logic ev, input logic [2:0] ew);
        tests++;
        if (av !== ev || aw !== ew) begin
            fails++;
            $display("FAIL %s: got valid=%0b way=%0d, expected valid=%0b way=%0d",
                     req, av, aw, ev, ew);
        end
    endtask

    task automatic access(input logic [7:0] v, input logic [15:0] l, input logic [23:0] r);
        @(negedge clk);
        way_valid_i = v; way_level_i = l; way_recency_i = r; done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R7 in reset", rest_valid_o, rest_way_o, 1'b0, 3'd0);
        rst_n = 1'b1;
        // Inputs change without the strobe: still blank.
        way_valid_i = 8'hFF; way_recency_i = 24'hFAC688;
        repeat (2) @(negedge clk);
        check("R7 blank before first capture", rest_valid_o, rest_way_o, 1'b0, 3'd0);

        for (int k = 0; k < NV; k++) begin
            access(VEC[k][51:44], VEC[k][43:28], VEC[k][27:4]);
            check($sformatf("table vector %0d (R1 R2 R3 R4 R5 R8)", k),
                  rest_valid_o, rest_way_o, VEC[k][3], VEC[k][2:0]);
        end

        // R6: result held while strobe stays low and inputs change.
        access(8'hFF, 16'h0000, 24'hFAC688);
        check("R6 capture", rest_valid_o, rest_way_o, 1'b1, 3'd7);
        @(negedge clk);
        way_valid_i = 8'h01; way_level_i = '0; way_recency_i = '0;
        repeat (3) @(negedge clk);
        check("R6 hold with strobe low", rest_valid_o, rest_way_o, 1'b1, 3'd7);
        // R6: recapture picks up the current inputs.
        access(8'h01, 16'h0000, 24'h000000);
        check("R6 recapture", rest_valid_o, rest_way_o, 1'b1, 3'd0);

        // R4: invalid way with lowest level and highest recency ignored.
        access(8'h7F, 16'h3FFF, 24'hE00000);
        check("R4 invalid way7", rest_valid_o, rest_way_o, 1'b1, 3'd0);

        // R5 after a valid result, then R8 back to valid.
        access(8'h00, 16'h0000, 24'h000000);
        check("R5 empty after valid", rest_valid_o, rest_way_o, 1'b0, 3'd0);
        access(8'h80, 16'h0000, 24'h000000);
        check("R8 single top way", rest_valid_o, rest_way_o, 1'b1, 3'd7);

        // R7: reset mid-run clears the result.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 reset clears", rest_valid_o, rest_way_o, 1'b0, 3'd0);
        rst_n = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule